// File: doc/BRIEF.md
# Serial Port Interrupt Status and Mask Unit

This unit sits beside the FIFOs of a serial port and produces that port's single interrupt line. Each cycle it turns the receive and transmit FIFO occupancy counts into a live status word. That word shows the empty and full conditions and whether each count has reached its programmable trigger level. The live flags and a set of one-cycle event pulses (receive overrun, framing error, parity error, receive timeout, modem-status change, transmit overrun) are latched into a sticky cause register. Software clears a sticky bit by writing a one to it.

The enable mask is never written directly. Software writes a one-set register to turn causes on and a one-clear register to turn them off, and reads the result back from a separate address. The interrupt line is high while any enabled cause is latched. Access is through a plain single-cycle register port: the write is strobed, the read data is combinational from the address, and the decode ignores the two low address bits.

Top module: `uart_irq_ctrl`

## Requirements
- R1: The live status word at 0x2C shows the receive flags and the transmit flags. Bit 0 is rx_count ≥ receive trigger, bit 1 is rx_count == 0 and bit 2 is rx_count == FIFO_DEPTH. Bit 3 is tx_count == 0 and bit 4 is tx_count == FIFO_DEPTH. All other bits except bit 13 read 0.
- R2: The transmit-trigger condition (tx_count ≥ transmit trigger) is bit 13 of the live word and is latched into bit 10 of the sticky word.
- R3: On every clock edge, each of live bits 0 to 4 that is 1 sets the same bit of the sticky word at 0x14. A sticky bit stays 1 until software clears it. Sticky bits 11 and 13 to 31 always read 0.
- R4: A one-cycle event pulse sets a sticky bit: receive overrun sets bit 5, framing error bit 6, parity error bit 7, receive timeout bit 8, modem status bit 9 and transmit overrun bit 12.
- R5: Writing 0x08 ORs the write data into the mask. Writing 0x0C clears the written one-bits from the mask. The mask reads back at 0x10, and writes to 0x10 leave it unchanged. Only bits 0 to 10 and 12 can be set.
- R6: Writing 0x14 clears each sticky bit written as 1. If the bit's source is active in the same cycle, the bit stays 1.
- R7: irq is 1 exactly when the bitwise AND of mask and sticky word is non-zero. It follows the register state in the same cycle.
- R8: After reset the mask and sticky registers are 0 and both trigger levels read 32.
- R9: The receive trigger at 0x20 and the transmit trigger at 0x44 take write data bits [CNT_W-1:0] and read back zero-extended. Addresses 0x08 and 0x0C and all unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| ev_rx_overrun | input | 1 | Receive overrun pulse |
| ev_framing | input | 1 | Framing error pulse |
| ev_parity | input | 1 | Parity error pulse |
| ev_rx_timeout | input | 1 | Receive timeout pulse |
| ev_modem | input | 1 | Modem status change pulse |
| ev_tx_overrun | input | 1 | Transmit overrun pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address, decoded word-aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the transmit-trigger flag, which sits at bit 13 in the live word but bit 10 in the sticky word. A design that reused one position for both would show the wrong bit in one word, and a mask enabling bit 10 would never raise irq. The bench clears a sticky bit while its source is still active, where a clear that won would drop a cause that is still present. It also writes the mask address directly, where a design that accepted the write would change irq behaviour. Trigger levels of 0 and FIFO_DEPTH, and counts on either side of each trigger, show up off-by-one comparisons in the live flags.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
   // byte offsets of the register window
   localparam logic [7:0] OFF_EN_SET  = 8'h08;
   localparam logic [7:0] OFF_EN_CLR  = 8'h0C;
   localparam logic [7:0] OFF_MASK    = 8'h10;
   localparam logic [7:0] OFF_CAUSE   = 8'h14;
   localparam logic [7:0] OFF_RX_TRIG = 8'h20;
   localparam logic [7:0] OFF_LIVE    = 8'h2C;
   localparam logic [7:0] OFF_TX_TRIG = 8'h44;

   // bit positions
   localparam int LIVE_TX_TRIG_BIT  = 13;
   localparam int CAUSE_TX_TRIG_BIT = 10;
   localparam int CAUSE_RX_OVR_BIT  = 5;
   localparam int CAUSE_FRAME_BIT   = 6;
   localparam int CAUSE_PARITY_BIT  = 7;
   localparam int CAUSE_TOUT_BIT    = 8;
   localparam int CAUSE_MODEM_BIT   = 9;
   localparam int CAUSE_TX_OVR_BIT  = 12;
   localparam int NUM_EVENTS        = 6;

   // bits that exist in the mask and cause registers
   localparam logic [31:0] CAUSE_IMPL = 32'h0000_17FF;

   typedef logic [31:0] word_t;
endpackage

// File: rtl/uirq_live_status.sv
module uirq_live_status
   import uirq_pkg::*;
#(
   parameter int FIFO_DEPTH = 64,
   parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic [CNT_W-1:0] rx_cnt,
   input  logic [CNT_W-1:0] tx_cnt,
   input  logic [CNT_W-1:0] rx_trig,
   input  logic [CNT_W-1:0] tx_trig,
   output word_t            live
);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

   always_comb begin
      live    = '0;
      live[0] = (rx_cnt >= rx_trig);
      live[1] = (rx_cnt == '0);
      live[2] = (rx_cnt == FULL_CNT);
      live[3] = (tx_cnt == '0);
      live[4] = (tx_cnt == FULL_CNT);
      live[LIVE_TX_TRIG_BIT] = (tx_cnt >= tx_trig);
   end
endmodule

// File: rtl/uirq_cause_mask.sv
module uirq_cause_mask
   import uirq_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [4:0]            live_lo,
   input  logic                  live_ttrig,
   input  logic [NUM_EVENTS-1:0] events,
   input  logic                  set_we,
   input  logic                  dis_we,
   input  logic                  clr_we,
   input  word_t                 wdata,
   output word_t                 cause,
   output word_t                 mask
);
   // event index order -> cause bit position
   localparam int EV_POS [NUM_EVENTS] = '{CAUSE_RX_OVR_BIT, CAUSE_FRAME_BIT,
      CAUSE_PARITY_BIT, CAUSE_TOUT_BIT, CAUSE_MODEM_BIT, CAUSE_TX_OVR_BIT};

   word_t set_vec, clr_vec, cause_d, mask_d;

   always_comb begin
      set_vec = '0;
      set_vec[4:0] = live_lo;
      set_vec[CAUSE_TX_TRIG_BIT] = live_ttrig;
      for (int i = 0; i < NUM_EVENTS; i++) begin
         if (events[i]) set_vec[EV_POS[i]] = 1'b1;
      end
   end

   assign clr_vec = clr_we ? wdata : '0;
   // set takes precedence over a simultaneous clear
   assign cause_d = ((cause & ~clr_vec) | set_vec) & CAUSE_IMPL;

   always_comb begin
      mask_d = mask;
      if (set_we) mask_d = mask_d | wdata;
      if (dis_we) mask_d = mask_d & ~wdata;
      mask_d = mask_d & CAUSE_IMPL;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause <= '0;
         mask  <= '0;
      end else begin
         cause <= cause_d;
         mask  <= mask_d;
      end
   end

   word_t ev_bits;
   always_comb begin
      ev_bits = '0;
      for (int i = 0; i < NUM_EVENTS; i++) ev_bits[EV_POS[i]] = events[i];
   end

   p_event_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (events != '0) |=> ((cause & $past(ev_bits)) == $past(ev_bits)));
   p_cause_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_we |=> ((cause & $past(cause)) == $past(cause)));
   p_live_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (live_lo != '0) |=> ((cause[4:0] & $past(live_lo)) == $past(live_lo)));
   p_ttrig_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
      live_ttrig |=> cause[CAUSE_TX_TRIG_BIT]);
   p_mask_ports_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_we || dis_we) |=> $stable(mask));
   p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && live_lo[1]) |=> cause[1]);
endmodule

// File: rtl/uirq_regfile.sv
module uirq_regfile
   import uirq_pkg::*;
#(
   parameter int FIFO_DEPTH = 64,
   parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
   parameter int ADDR_W     = 8,
   parameter int TRIG_RESET = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  word_t             reg_wdata,
   input  word_t             live,
   input  word_t             cause,
   input  word_t             mask,
   output logic [CNT_W-1:0]  rx_trig,
   output logic [CNT_W-1:0]  tx_trig,
   output logic              set_we,
   output logic              dis_we,
   output logic              clr_we,
   output word_t             reg_rdata
);
   localparam logic [CNT_W-1:0] TRIG_INIT = CNT_W'(TRIG_RESET);

   logic [ADDR_W-1:0] waddr;
   logic              unused_lsb;
   assign waddr      = {reg_addr[ADDR_W-1:2], 2'b00};
   assign unused_lsb = ^reg_addr[1:0];

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
      return a == ADDR_W'(off);
   endfunction

   assign set_we = reg_we && hit(waddr, OFF_EN_SET);
   assign dis_we = reg_we && hit(waddr, OFF_EN_CLR);
   assign clr_we = reg_we && hit(waddr, OFF_CAUSE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_trig <= TRIG_INIT;
         tx_trig <= TRIG_INIT;
      end else if (reg_we) begin
         if (hit(waddr, OFF_RX_TRIG)) rx_trig <= reg_wdata[CNT_W-1:0];
         if (hit(waddr, OFF_TX_TRIG)) tx_trig <= reg_wdata[CNT_W-1:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (hit(waddr, OFF_MASK))    reg_rdata = mask;
      if (hit(waddr, OFF_CAUSE))   reg_rdata = cause;
      if (hit(waddr, OFF_LIVE))    reg_rdata = live;
      if (hit(waddr, OFF_RX_TRIG)) reg_rdata = 32'(rx_trig);
      if (hit(waddr, OFF_TX_TRIG)) reg_rdata = 32'(tx_trig);
   end

   p_one_decode_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({set_we, dis_we, clr_we}));
   p_trig_reset_r8: assert property (@(posedge clk)
      !rst_n |=> (rx_trig == TRIG_INIT && tx_trig == TRIG_INIT));
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uirq_pkg::*;
#(
   parameter int FIFO_DEPTH = 64,
   parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
   parameter int ADDR_W     = 8,
   parameter int TRIG_RESET = 32,
   parameter bit IRQ_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  rx_count,
   input  logic [CNT_W-1:0]  tx_count,
   input  logic              ev_rx_overrun,
   input  logic              ev_framing,
   input  logic              ev_parity,
   input  logic              ev_rx_timeout,
   input  logic              ev_modem,
   input  logic              ev_tx_overrun,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq
);
   generate
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("FIFO_DEPTH must be at least 2");
      end
      if ((1 << CNT_W) <= FIFO_DEPTH) begin : g_bad_cntw
         $error("CNT_W too narrow for FIFO_DEPTH");
      end
      if (ADDR_W < 7) begin : g_bad_addr
         $error("ADDR_W must reach offset 0x44");
      end
      if (TRIG_RESET > FIFO_DEPTH) begin : g_bad_trig
         $error("TRIG_RESET above FIFO_DEPTH");
      end
   endgenerate

   word_t            live, cause, mask;
   logic [CNT_W-1:0] rx_trig, tx_trig;
   logic             set_we, dis_we, clr_we;
   logic             irq_raw;

   uirq_live_status #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_live (
      .rx_cnt (rx_count),
      .tx_cnt (tx_count),
      .rx_trig(rx_trig),
      .tx_trig(tx_trig),
      .live   (live)
   );

   uirq_regfile #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
                  .TRIG_RESET(TRIG_RESET)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_we   (reg_we),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .live     (live),
      .cause    (cause),
      .mask     (mask),
      .rx_trig  (rx_trig),
      .tx_trig  (tx_trig),
      .set_we   (set_we),
      .dis_we   (dis_we),
      .clr_we   (clr_we),
      .reg_rdata(reg_rdata)
   );

   uirq_cause_mask u_cause (
      .clk       (clk),
      .rst_n     (rst_n),
      .live_lo   (live[4:0]),
      .live_ttrig(live[LIVE_TX_TRIG_BIT]),
      .events    ({ev_tx_overrun, ev_modem, ev_rx_timeout,
                   ev_parity, ev_framing, ev_rx_overrun}),
      .set_we    (set_we),
      .dis_we    (dis_we),
      .clr_we    (clr_we),
      .wdata     (reg_wdata),
      .cause     (cause),
      .mask      (mask)
   );

   assign irq_raw = |(mask & cause);

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_raw;
         end
         assign irq = irq_q;
      end else begin : g_irq_direct
         assign irq = irq_raw;
         p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ((mask & cause) == '0) |-> !irq);
      end
   endgenerate

   p_no_mask_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0 && $past(mask) == '0) |-> !irq);
endmodule

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;
   localparam int DEPTH = 64;
   localparam int CW    = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] rx_count = '0, tx_count = '0;
   logic          ev_rx_overrun = 0, ev_framing = 0, ev_parity = 0;
   logic          ev_rx_timeout = 0, ev_modem = 0, ev_tx_overrun = 0;
   logic          reg_we = 0;
   logic [7:0]    reg_addr = 8'h00;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          irq;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   uart_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
      .ev_rx_overrun(ev_rx_overrun), .ev_framing(ev_framing),
      .ev_parity(ev_parity), .ev_rx_timeout(ev_rx_timeout),
      .ev_modem(ev_modem), .ev_tx_overrun(ev_tx_overrun),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   // reference model state
   logic [31:0] m_mask = '0, m_cause = '0;
   int          m_rt = 32, m_tt = 32;
   localparam logic [31:0] IMPL = 32'h17FF;

   function automatic logic [31:0] m_live();
      logic [31:0] v = '0;
      v[0]  = int'(rx_count) >= m_rt;
      v[1]  = rx_count == 0;
      v[2]  = int'(rx_count) == DEPTH;
      v[3]  = tx_count == 0;
      v[4]  = int'(tx_count) == DEPTH;
      v[13] = int'(tx_count) >= m_tt;
      return v;
   endfunction

   function automatic logic [31:0] m_read();
      case ({reg_addr[7:2], 2'b00})
         8'h10:   return m_mask;
         8'h14:   return m_cause;
         8'h2C:   return m_live();
         8'h20:   return 32'(m_rt);
         8'h44:   return 32'(m_tt);
         default: return 32'h0;
      endcase
   endfunction

   function automatic string addr_tag();
      case ({reg_addr[7:2], 2'b00})
         8'h10:   return "R5";
         8'h14:   return "R3";
         8'h2C:   return "R1";
         default: return "R9";
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mask = '0; m_cause = '0; m_rt = 32; m_tt = 32;
      end else begin
         logic [31:0] lv, setv, clrv, nm;
         lv = m_live();
         setv = {18'b0, ev_tx_overrun, 1'b0, lv[13], ev_modem, ev_rx_timeout,
                 ev_parity, ev_framing, ev_rx_overrun, lv[4:0]};
         clrv = '0;
         nm = m_mask;
         if (reg_we) begin
            case ({reg_addr[7:2], 2'b00})
               8'h08: nm = nm | reg_wdata;
               8'h0C: nm = nm & ~reg_wdata;
               8'h14: clrv = reg_wdata;
               8'h20: m_rt = int'(reg_wdata[CW-1:0]);
               8'h44: m_tt = int'(reg_wdata[CW-1:0]);
               default: ;
            endcase
         end
         m_cause = ((m_cause & ~clrv) | setv) & IMPL;
         m_mask  = nm & IMPL;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FIFO check FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // per-cycle comparison, sampled at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         check("R7 irq", 32'(irq), 32'(|(m_mask & m_cause)));
         check(addr_tag(), reg_rdata, m_read());
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
      #1;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      step(1);
      reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic look(input logic [7:0] a);
      reg_addr = a;
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         total++; bad++;
         $display("FAIL watchdog: actual=%0d expected<100000 cycles", cycles);
         finish_run();
      end
   end

   initial begin
      reg_addr = 8'h10;
      step(3);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 mask after reset", reg_rdata, 32'h0);
      #1; look(8'h20);
      check("R8 rx trigger reset", reg_rdata, 32'd32);
      #1; look(8'h44);
      check("R8 tx trigger reset", reg_rdata, 32'd32);

      // R1: live flags across counts
      #1; rx_count = 7'd31; tx_count = 7'd64; look(8'h2C);
      check("R1 live rx below trig, tx full", reg_rdata, 32'h0000_2010);
      #1; rx_count = 7'd32; tx_count = 7'd5; look(8'h2C);
      check("R1 live rx at trig", reg_rdata, 32'h0000_0001);
      #1; rx_count = 7'd64; tx_count = 7'd0; look(8'h2C);
      check("R1 live rx full tx empty", reg_rdata, 32'h0000_0009 | 32'h4);

      // R2: transmit trigger position
      #1; rx_count = 7'd10; tx_count = 7'd40; look(8'h2C);
      check("R2 live bit13", 32'(reg_rdata[13]), 32'd1);
      check("R2 live bit10 clear", 32'(reg_rdata[10]), 32'd0);
      #1; look(8'h14);
      check("R2 sticky bit10", 32'(reg_rdata[10]), 32'd1);
      check("R2 sticky bit13 clear", 32'(reg_rdata[13]), 32'd0);

      // R3: clear everything, sticky stays clear with no source
      #1; tx_count = 7'd5;
      step(0);
      wr(8'h14, 32'hFFFF_FFFF);
      look(8'h14);
      check("R3 cleared sticky", reg_rdata, 32'h0);

      // R4: event pulses
      #1; ev_parity = 1; ev_modem = 1; step(1); ev_parity = 0; ev_modem = 0;
      look(8'h14);
      check("R4 parity+modem", reg_rdata, 32'h0000_0280);
      #1; ev_rx_overrun = 1; ev_framing = 1; ev_rx_timeout = 1; ev_tx_overrun = 1;
      step(1);
      ev_rx_overrun = 0; ev_framing = 0; ev_rx_timeout = 0; ev_tx_overrun = 0;
      look(8'h14);
      check("R4 all events", reg_rdata, 32'h0000_13E0);

      // R7: enable, irq
      #1; check("R7 irq before enable", 32'(irq), 32'd0);
      wr(8'h08, 32'h0000_0080);
      step(0); @(negedge clk);
      check("R7 irq enabled parity", 32'(irq), 32'd1);
      #1; wr(8'h14, 32'h0000_0080);
      @(negedge clk);
      check("R7 irq after clear", 32'(irq), 32'd0);

      // R5: set/clear/direct writes
      #1; wr(8'h08, 32'hFFFF_FFFF);
      look(8'h10);
      check("R5 mask implemented bits", reg_rdata, 32'h0000_17FF);
      #1; wr(8'h0C, 32'h0000_0400);
      look(8'h10);
      check("R5 mask disable bit10", reg_rdata, 32'h0000_13FF);
      #1; wr(8'h10, 32'h0);
      look(8'h10);
      check("R5 direct mask write ignored", reg_rdata, 32'h0000_13FF);

      // R6: clear while source active (rx empty)
      #1; rx_count = 7'd0; step(1);
      wr(8'h14, 32'h0000_0002);
      look(8'h14);
      check("R6 set beats clear", 32'(reg_rdata[1]), 32'd1);
      check("R7 irq with source", 32'(irq), 32'd1);

      // R9: trigger write, boundaries, unmapped reads
      #1; wr(8'h20, 32'hFFFF_FF00);
      look(8'h20);
      check("R9 rx trigger zero", reg_rdata, 32'h0);
      #1; look(8'h2C);
      check("R9 trig zero -> bit0", 32'(reg_rdata[0]), 32'd1);
      #1; wr(8'h45, 32'd64);
      tx_count = 7'd63; look(8'h44);
      check("R9 tx trigger depth", reg_rdata, 32'd64);
      #1; look(8'h2C);
      check("R9 tx below depth trig", 32'(reg_rdata[13]), 32'd0);
      #1; tx_count = 7'd64; look(8'h2C);
      check("R9 tx at depth trig", 32'(reg_rdata[13]), 32'd1);
      #1; look(8'h08);
      check("R9 enable reads zero", reg_rdata, 32'h0);
      #1; look(8'h80);
      check("R9 unmapped reads zero", reg_rdata, 32'h0);

      // disable all, irq drops
      #1; wr(8'h0C, 32'hFFFF_FFFF);
      @(negedge clk);
      check("R7 irq masked off", 32'(irq), 32'd0);

      // mixed traffic against the model
      for (int k = 0; k < 200; k++) begin
         #1;
         rx_count = 7'((k * 7) % 65);
         tx_count = 7'((k * 11) % 65);
         ev_framing = (k % 9 == 0);
         ev_tx_overrun = (k % 13 == 0);
         case (k % 5)
            0: wr(8'h08, 32'(k * 37));
            1: wr(8'h14, 32'(k * 91));
            2: wr(8'h0C, 32'(k * 5));
            default: begin reg_addr = (k % 2) ? 8'h14 : 8'h2C; step(1); end
         endcase
      end
      ev_framing = 0; ev_tx_overrun = 0;
      step(2);
      finish_run();
   end
endmodule